// File: doc/BRIEF.md
# Sprite Status and Fifth-Sprite Tracker

This block keeps the sprite-related part of a video display processor's status byte. Each cycle, a sprite scanner may present one sprite under evaluation: its index, its vertical position byte and whether it covers the current scan line. The block decides whether that sprite is processed. It counts the processed sprites that sit on the line and signals which of them may be shown. When the count would pass the per-line limit, it raises the fifth-sprite flag.

The status byte carries four items: a frame flag, the fifth-sprite flag, a collision flag and a 5-bit sprite number. The sprite number acts as a transparent latch. It tracks the index of each processed sprite while the fifth-sprite flag is clear, holds once the flag sets, and starts tracking again as soon as a status read clears the flag, even partway through a frame. Collisions reported by the pixel logic count only inside the active display area. Processing on a line stops at a sprite whose index reaches the maximum-sprite setting. In 24-row mode it also stops at the terminator position value. A status read clears all three flags, except that an event arriving in the same cycle as the read survives it.

Top module: `sprite_status_tracker`

## Requirements
- R1: After reset, status_byte reads 0x00 and sprite_show is low.
- R2: status_byte bit 7 is the frame flag, bit 6 the fifth-sprite flag, bit 5 the collision flag, and bits 4..0 the sprite number.
- R3: While the fifth-sprite flag is clear, each processed sprite loads its index into the sprite number field; the new value is visible the cycle after the evaluation.
- R4: A processed on-line sprite that arrives when line_limit sprites have already been shown on this line sets the fifth-sprite flag and leaves its own index in the number field. The field then holds while the flag stays set.
- R5: A status read clears the fifth-sprite flag. The next processed sprite loads the number field again, including a sprite evaluated in the read cycle itself.
- R6: pix_collide sets the collision flag only when line_num is below 192 (row30 = 0) or below 240 (row30 = 1).
- R7: With row30 = 0, a sprite whose position byte is 0xD0 is not processed. No later sprite on that line is processed until line_start.
- R8: With row30 = 1, a position byte of 0xD0 is processed like any other value.
- R9: A sprite whose index is greater than max_sprite is not processed. After the sprite with index equal to max_sprite, no further sprite on that line is processed.
- R10: A status read clears the collision and frame flags one cycle later. A collision, overflow or vblank event in the read cycle leaves its flag set.
- R11: sprite_show is high in the evaluation cycle for each of the first line_limit processed on-line sprites of a line, and low otherwise.
- R12: A vblank pulse sets the frame flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Start of a new line's sprite scan; clears the per-line count and stop state |
| eval_valid | input | 1 | A sprite is presented for evaluation this cycle |
| eval_index | input | 5 | Index of the presented sprite |
| eval_y | input | 8 | Vertical position byte of the presented sprite |
| eval_on_line | input | 1 | The presented sprite covers the current line |
| row30 | input | 1 | 1 selects 30-row mode, 0 selects 24-row mode |
| max_sprite | input | 5 | Highest sprite index that is processed |
| line_limit | input | 6 | Number of sprites that may be shown on one line |
| pix_collide | input | 1 | Pixel logic reports overlapping sprite pixels |
| line_num | input | 9 | Current scan line number |
| vblank | input | 1 | End-of-frame pulse |
| status_rd | input | 1 | Status byte read strobe |
| status_byte | output | 8 | Frame, fifth-sprite, collision flags and sprite number |
| sprite_show | output | 1 | The presented sprite is accepted for display |

## Verification
Several pairs of events can fall in the same cycle. A status read can coincide with a collision, with an overflowing sprite or with vblank, and a status read can coincide with the evaluation of a sprite while the fifth-sprite flag is set. The bench drives each pair together in one cycle. It then checks whether the flag stays set after the read, and whether the number field picks up the index evaluated in that cycle. It also provokes a mid-line read that reopens the number field, and checks that the next sprite's index appears there.

// File: rtl/spr_stat_pkg.sv
package spr_stat_pkg;

  localparam int unsigned STAT_NUM_W = 5;

  typedef struct packed {
    logic                  frame;
    logic                  fifth;
    logic                  coll;
    logic [STAT_NUM_W-1:0] num;
  } status_t;

  localparam logic [7:0] DEF_TERM_Y = 8'hD0;

endpackage

// File: rtl/spr_scan_limit.sv
module spr_scan_limit #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned CNT_W  = 6,
  parameter logic [7:0]  TERM_Y = 8'hD0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             eval_valid,
  input  logic [IDX_W-1:0] eval_index,
  input  logic [7:0]       eval_y,
  input  logic             eval_on_line,
  input  logic             row30,
  input  logic [IDX_W-1:0] max_sprite,
  input  logic [CNT_W-1:0] line_limit,
  output logic             proc,
  output logic             show,
  output logic             ovf
);

  logic             stop_q, stop_d, stop_cur;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_cur;
  logic             term_hit, over_max, at_max, room;

  always_comb begin
    stop_cur = stop_q & ~line_start;
    cnt_cur  = line_start ? '0 : cnt_q;
    term_hit = eval_valid & ~row30 & (eval_y == TERM_Y);
    over_max = eval_index > max_sprite;
    at_max   = eval_index == max_sprite;
    proc     = eval_valid & ~stop_cur & ~term_hit & ~over_max;
    room     = cnt_cur < line_limit;
    show     = proc & eval_on_line & room;
    ovf      = proc & eval_on_line & ~room;
    stop_d   = stop_cur;
    if (eval_valid && !stop_cur && (term_hit || over_max || at_max)) begin
      stop_d = 1'b1;
    end
    cnt_d = cnt_cur;
    if (show) begin
      cnt_d = cnt_cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stop_q <= stop_d;
      cnt_q  <= cnt_d;
    end
  end

  p_term_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    term_hit |=> (line_start || !proc));

  p_max_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && at_max) |=> (line_start || !proc));

  p_show_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (show && !line_start) |=> (line_start || ($past(cnt_cur) < cnt_q) || !$stable(line_limit)));

endmodule

// File: rtl/spr_fifth_track.sv
module spr_fifth_track #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc,
  input  logic             ovf,
  input  logic [IDX_W-1:0] eval_index,
  input  logic             status_rd,
  output logic             fifth_q,
  output logic [IDX_W-1:0] num_q
);

  logic             fifth_d, open;
  logic [IDX_W-1:0] num_d;

  always_comb begin
    open    = ~fifth_q | status_rd;
    fifth_d = (fifth_q & ~status_rd) | ovf;
    num_d   = (open && proc) ? eval_index : num_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifth_q <= 1'b0;
      num_q   <= '0;
    end else begin
      fifth_q <= fifth_d;
      num_q   <= num_d;
    end
  end

  p_num_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifth_q && !status_rd) |=> $stable(num_q));

  p_fifth_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> fifth_q);

  p_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (proc && !fifth_q) |=> (num_q == $past(eval_index)));

endmodule

// File: rtl/spr_flag_unit.sv
module spr_flag_unit #(
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned ACTIVE_24 = 192,
  parameter int unsigned ACTIVE_30 = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_collide,
  input  logic [LINE_W-1:0] line_num,
  input  logic              row30,
  input  logic              vblank,
  input  logic              status_rd,
  output logic              coll_q,
  output logic              frame_q
);

  localparam int unsigned NFLAG = 2;
  localparam logic [LINE_W-1:0] LIM24 = LINE_W'(ACTIVE_24);
  localparam logic [LINE_W-1:0] LIM30 = LINE_W'(ACTIVE_30);

  logic             active;
  logic [NFLAG-1:0] set_v, flag_q, flag_d;

  always_comb begin
    active   = line_num < (row30 ? LIM30 : LIM24);
    set_v[0] = pix_collide & active;
    set_v[1] = vblank;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_comb flag_d[g] = (flag_q[g] & ~status_rd) | set_v[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= flag_d[g];
    end
  end

  assign coll_q  = flag_q[0];
  assign frame_q = flag_q[1];

  p_coll_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_collide && active) |=> coll_q);

  p_coll_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !coll_q) |=> !coll_q);

  p_coll_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !pix_collide) |=> !coll_q);

  p_frame_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> frame_q);

endmodule

// File: rtl/sprite_status_tracker.sv
module sprite_status_tracker
  import spr_stat_pkg::*;
#(
  parameter int unsigned NUM_SPR   = 32,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned ACTIVE_24 = 192,
  parameter int unsigned ACTIVE_30 = 240,
  parameter logic [7:0]  TERM_Y    = DEF_TERM_Y,
  localparam int unsigned IDX_W    = $clog2(NUM_SPR),
  localparam int unsigned CNT_W    = $clog2(NUM_SPR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              eval_valid,
  input  logic [IDX_W-1:0]  eval_index,
  input  logic [7:0]        eval_y,
  input  logic              eval_on_line,
  input  logic              row30,
  input  logic [IDX_W-1:0]  max_sprite,
  input  logic [CNT_W-1:0]  line_limit,
  input  logic              pix_collide,
  input  logic [LINE_W-1:0] line_num,
  input  logic              vblank,
  input  logic              status_rd,
  output logic [7:0]        status_byte,
  output logic              sprite_show
);

  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             proc, ovf;
  logic             fifth, coll, frame;
  logic [IDX_W-1:0] num;
  status_t          stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  spr_scan_limit #(.IDX_W(IDX_W), .CNT_W(CNT_W), .TERM_Y(TERM_Y)) u_limit (
    .clk(clk), .rst_n(rst_int_n), .line_start(line_start),
    .eval_valid(eval_valid), .eval_index(eval_index), .eval_y(eval_y),
    .eval_on_line(eval_on_line), .row30(row30), .max_sprite(max_sprite),
    .line_limit(line_limit), .proc(proc), .show(sprite_show), .ovf(ovf)
  );

  spr_fifth_track #(.IDX_W(IDX_W)) u_fifth (
    .clk(clk), .rst_n(rst_int_n), .proc(proc), .ovf(ovf),
    .eval_index(eval_index), .status_rd(status_rd),
    .fifth_q(fifth), .num_q(num)
  );

  spr_flag_unit #(.LINE_W(LINE_W), .ACTIVE_24(ACTIVE_24), .ACTIVE_30(ACTIVE_30)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .pix_collide(pix_collide), .line_num(line_num),
    .row30(row30), .vblank(vblank), .status_rd(status_rd),
    .coll_q(coll), .frame_q(frame)
  );

  always_comb begin
    stat.frame  = frame;
    stat.fifth  = fifth;
    stat.coll   = coll;
    stat.num    = STAT_NUM_W'(num);
    status_byte = stat;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_int_n |=> (status_byte[6:5] == 2'b00 || rst_int_n));

endmodule

// File: tb/sprite_status_tracker_bench.sv
`timescale 1ns/1ps
module sprite_status_tracker_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic line_start, eval_valid, eval_on_line, row30, pix_collide, vblank, status_rd;
  logic [4:0] eval_index, max_sprite;
  logic [7:0] eval_y;
  logic [5:0] line_limit;
  logic [8:0] line_num;
  logic [7:0] status_byte;
  logic sprite_show;
  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sprite_status_tracker u_sprite_status_tracker (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .eval_valid(eval_valid),
    .eval_index(eval_index), .eval_y(eval_y), .eval_on_line(eval_on_line),
    .row30(row30), .max_sprite(max_sprite), .line_limit(line_limit),
    .pix_collide(pix_collide), .line_num(line_num), .vblank(vblank),
    .status_rd(status_rd), .status_byte(status_byte), .sprite_show(sprite_show)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ev(input logic [4:0] idx, input logic [7:0] y, input logic on, output logic shw);
    eval_valid = 1'b1; eval_index = idx; eval_y = y; eval_on_line = on;
    #1 shw = sprite_show;
    @(negedge clk);
    eval_valid = 1'b0; eval_on_line = 1'b0;
  endtask

  task automatic new_line();
    line_start = 1'b1; @(negedge clk); line_start = 1'b0;
  endtask

  task automatic rd();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_byte, 0);
    chk("R1 show", sprite_show, 0);
  endtask

  task automatic t_follow();
    logic s;
    line_limit = 6'd4; max_sprite = 5'd31; row30 = 1'b0;
    new_line();
    ev(5'd3, 8'd10, 1'b0, s);
    chk("R3 num after 3", status_byte[4:0], 3);
    ev(5'd7, 8'd10, 1'b0, s);
    chk("R3 num after 7", status_byte[4:0], 7);
    chk("R2 flags clear", status_byte[7:5], 0);
  endtask

  task automatic t_fifth();
    logic s;
    new_line();
    for (int i = 0; i < 4; i++) begin
      ev(5'(i), 8'd20, 1'b1, s);
      chk("R11 shown within limit", s, 1);
    end
    ev(5'd4, 8'd20, 1'b1, s);
    chk("R11 fifth not shown", s, 0);
    chk("R4 fifth flag bit6", status_byte[6], 1);
    chk("R4 num at overflow", status_byte[4:0], 4);
    ev(5'd5, 8'd20, 1'b1, s);
    chk("R4 num frozen", status_byte[4:0], 4);
  endtask

  task automatic t_resume();
    logic s;
    rd();
    chk("R5 fifth cleared", status_byte[6], 0);
    chk("R5 num kept until scan", status_byte[4:0], 4);
    ev(5'd9, 8'd20, 1'b0, s);
    chk("R5 num resumes", status_byte[4:0], 9);
  endtask

  task automatic t_term24();
    logic s;
    row30 = 1'b0;
    new_line();
    ev(5'd2, 8'hD0, 1'b1, s);
    chk("R7 terminator not shown", s, 0);
    chk("R7 num unchanged", status_byte[4:0], 9);
    ev(5'd3, 8'd30, 1'b1, s);
    chk("R7 later sprite blocked", s, 0);
    chk("R7 num still unchanged", status_byte[4:0], 9);
    new_line();
    ev(5'd3, 8'd30, 1'b1, s);
    chk("R7 new line resumes", s, 1);
  endtask

  task automatic t_term30();
    logic s;
    row30 = 1'b1;
    new_line();
    ev(5'd6, 8'hD0, 1'b1, s);
    chk("R8 D0 shown in 30-row", s, 1);
    chk("R8 num follows", status_byte[4:0], 6);
    row30 = 1'b0;
  endtask

  task automatic t_max();
    logic s;
    max_sprite = 5'd3;
    new_line();
    ev(5'd2, 8'd40, 1'b1, s);
    chk("R9 below max shown", s, 1);
    ev(5'd3, 8'd40, 1'b1, s);
    chk("R9 at max shown", s, 1);
    ev(5'd4, 8'd40, 1'b1, s);
    chk("R9 past max blocked", s, 0);
    chk("R9 num holds max", status_byte[4:0], 3);
    new_line();
    ev(5'd5, 8'd40, 1'b1, s);
    chk("R9 over max blocked", s, 0);
    ev(5'd1, 8'd40, 1'b1, s);
    chk("R9 stopped after over-max", s, 0);
    chk("R9 num unchanged", status_byte[4:0], 3);
    max_sprite = 5'd31;
  endtask

  task automatic coll_at(input logic [8:0] ln, input logic r30);
    row30 = r30; line_num = ln; pix_collide = 1'b1;
    @(negedge clk); pix_collide = 1'b0;
  endtask

  task automatic t_coll();
    rd();
    coll_at(9'd191, 1'b0);
    chk("R6 line 191 24-row", status_byte[5], 1);
    rd();
    chk("R10 read clears coll", status_byte[5], 0);
    coll_at(9'd192, 1'b0);
    chk("R6 line 192 24-row", status_byte[5], 0);
    coll_at(9'd239, 1'b1);
    chk("R6 line 239 30-row", status_byte[5], 1);
    rd();
    coll_at(9'd240, 1'b1);
    chk("R6 line 240 30-row", status_byte[5], 0);
    row30 = 1'b0;
  endtask

  task automatic t_same_cycle();
    logic s;
    coll_at(9'd10, 1'b0);
    line_num = 9'd10; pix_collide = 1'b1; status_rd = 1'b1;
    @(negedge clk); pix_collide = 1'b0; status_rd = 1'b0;
    chk("R10 coll survives read", status_byte[5], 1);
    rd();
    chk("R10 next read clears", status_byte[5], 0);
    vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    chk("R12 frame set", status_byte[7], 1);
    vblank = 1'b1; status_rd = 1'b1; @(negedge clk); vblank = 1'b0; status_rd = 1'b0;
    chk("R10 frame survives read", status_byte[7], 1);
    rd();
    chk("R10 frame cleared", status_byte[7], 0);
    line_limit = 6'd1;
    new_line();
    ev(5'd0, 8'd50, 1'b1, s);
    status_rd = 1'b1;
    ev(5'd1, 8'd50, 1'b1, s);
    status_rd = 1'b0;
    chk("R10 fifth survives read", status_byte[6], 1);
    chk("R5 num loads in read cycle", status_byte[4:0], 1);
    line_limit = 6'd4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_start = 1'b0; eval_valid = 1'b0; eval_on_line = 1'b0;
    row30 = 1'b0; pix_collide = 1'b0; vblank = 1'b0; status_rd = 1'b0;
    eval_index = '0; eval_y = '0; max_sprite = 5'd31; line_limit = 6'd4; line_num = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_follow();
    t_fifth();
    t_resume();
    t_term24();
    t_term30();
    t_max();
    t_coll();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule